// File: doc/BRIEF.md
# Dual-Channel Power Control Register Slave (I2C)

This block is an I2C bus slave. It holds the control settings of a device with two power channels. It keeps one control register per channel. A host writes these registers and can read them back over the same two-wire bus. Each byte read back combines the stored control bits with live fault flags. One flag reports an over-temperature shutdown. A second flag reports a current-limit trip on that byte's channel.

A power-good input gates the whole interface. While power-good is low:
- the slave answers no address;
- both registers stay cleared, so both channels stay disabled.

A single select input picks one of two 7-bit slave addresses, which allows two devices on one bus.

The bus lines enter the block as raw samples. Each line first passes through a two-flop synchronizer and then a stability filter. START and STOP are recognised from the filtered lines. The block pulls SDA low through one open-drain enable output.

Top module: `pwrCtrlI2cSlave`

## Requirements
- R1: The slave acknowledges (drives SDA low on the ninth clock) only the 7-bit address 0001000 when addrSel is 0 and only 0001001 when addrSel is 1. Every other address is left unacknowledged and the rest of that transfer is ignored.
- R2: In a write (R/W bit 0), the first data byte after the address loads ctrlOut1 from data bits 5:0. The second data byte loads ctrlOut2 from data bits 5:0. Both bytes are acknowledged. Data bits 7:6 are not stored.
- R3: Write data bytes after the second one are acknowledged and change neither register.
- R4: In a read (R/W bit 1), the slave sends bytes most significant bit first. The first byte is channel 1's, the next is channel 2's, and the sequence then alternates between the channels for as long as the master acknowledges.
- R5: A read byte is laid out as {overload flag of that channel, thermalFault, the 6 stored control bits}. Bit 7 is the overload flag, bit 6 is the thermal flag, and a 1 in either means the fault is present.
- R6: The fault flags in a read byte are captured when that byte is loaded, at the falling SCL edge that ends the preceding acknowledge. A flag that changes during the byte is first seen in the following byte.
- R7: After the master does not acknowledge a read byte, the slave releases SDA and sends nothing more until the next START.
- R8: While powerGood is low, both registers read as zero, SDA is never pulled low and no address is acknowledged. The registers are still zero after powerGood returns high.
- R9: A channel's enable (stored bit 0) is updated in the same clock cycle as its configuration bits 5:1. An enable never turns on while that register's configuration still holds older values.
- R10: A pulse on SCL that lasts fewer than FILT_LEN clock cycles is ignored. Such a pulse neither shifts a bit nor disturbs the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus lines |
| rstN | input | 1 | Synchronous active-low reset |
| powerGood | input | 1 | High when supply is valid; low clears and silences the slave |
| addrSel | input | 1 | Selects slave address 0001000 (0) or 0001001 (1) |
| sclIn | input | 1 | Sampled bus clock line |
| sdaIn | input | 1 | Sampled bus data line |
| sdaDriveLow | output | 1 | 1 pulls SDA low (open-drain enable) |
| thermalFault | input | 1 | Over-temperature shutdown indication |
| overload1 | input | 1 | Channel 1 current-limit trip |
| overload2 | input | 1 | Channel 2 current-limit trip |
| ctrlOut1 | output | 6 | Channel 1 control bits; bit 0 is the enable |
| ctrlOut2 | output | 6 | Channel 2 control bits; bit 0 is the enable |

## Verification
The assertions take the following for granted:
- powerGood and the fault flags are already synchronous to clk;
- every register change is caused either by a write strobe from the controller or by powerGood going low.

These assumptions hold only if each SCL phase stays much longer than the synchronizer and filter latency together. The stimulus therefore holds every SCL quarter period at 20 clocks against a front-end delay of about 6. The master changes SDA only while SCL is low, except for deliberate START and STOP conditions. The one deliberate violation is an SCL glitch of 2 cycles. That glitch stays below the filter length, so every edge the controller sees remains a legal bus edge.

// File: rtl/i2cRegPkg.sv
`timescale 1ns/1ps
package i2cRegPkg;
  localparam int BYTE_W = 8;
  localparam int CTRL_W = BYTE_W - 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WRB, ST_WACK, ST_RDB, ST_RACK
  } ctrlStateT;

  typedef struct packed {
    logic rxShift;
    logic txLoad;
    logic txSel;
    logic txShift;
    logic wrReg1;
    logic wrReg2;
  } strobeT;
endpackage

// File: rtl/i2cLineFilter.sv
`timescale 1ns/1ps
module i2cLineFilter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaF,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  localparam int N_LINES = 2;
  localparam int CNT_W = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_LEN - 1);

  logic [N_LINES-1:0] rawIn;
  logic [N_LINES-1:0] lineF;
  logic sclPrev, sdaPrev;

  assign rawIn = {sdaIn, sclIn};

  genvar g;
  generate
    for (g = 0; g < N_LINES; g++) begin : gLine
      logic s1, s2, filt;
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          s1   <= 1'b1;
          s2   <= 1'b1;
          filt <= 1'b1;
          cnt  <= '0;
        end else begin
          s1 <= rawIn[g];
          s2 <= s1;
          if (s2 == filt) begin
            cnt <= '0;
          end else if (cnt == CNT_LAST) begin
            filt <= s2;
            cnt  <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
      assign lineF[g] = filt;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= lineF[0];
      sdaPrev <= lineF[1];
    end
  end

  assign sdaF     = lineF[1];
  assign sclRise  = lineF[0] & ~sclPrev;
  assign sclFall  = ~lineF[0] & sclPrev;
  assign startDet = lineF[0] & sclPrev & sdaPrev & ~lineF[1];
  assign stopDet  = lineF[0] & sclPrev & ~sdaPrev & lineF[1];
endmodule

// File: rtl/i2cSlaveCtrl.sv
`timescale 1ns/1ps
module i2cSlaveCtrl
  import i2cRegPkg::*;
#(
  parameter logic [6:0] ADDR_BASE = 7'b0001000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              powerGood,
  input  logic              addrSel,
  input  logic              sdaF,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic              txMsb,
  input  logic [BYTE_W-1:0] rxByte,
  output strobeT            strb,
  output logic              sdaDriveLow
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  ctrlStateT        state;
  logic [CNT_W-1:0] bitCnt;
  logic             gotByte, rwBit, ackDrive, mAck, rdSel;
  logic [1:0]       wrIdx;
  logic [6:0]       myAddr;
  logic             active;

  assign myAddr = ADDR_BASE | {6'b0, addrSel};
  assign active = powerGood & ~startDet & ~stopDet;

  always_comb begin
    strb = '0;
    if (active) begin
      strb.rxShift = sclRise && (state == ST_ADDR || state == ST_WRB);
      strb.txShift = sclFall && state == ST_RDB && !gotByte;
      strb.txLoad  = sclFall && ((state == ST_AACK && rwBit) ||
                                 (state == ST_RACK && mAck));
      strb.txSel   = (state == ST_RACK) ? ~rdSel : 1'b0;
      strb.wrReg1  = sclFall && state == ST_WRB && gotByte && wrIdx == 2'd0;
      strb.wrReg2  = sclFall && state == ST_WRB && gotByte && wrIdx == 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !powerGood) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      gotByte  <= 1'b0;
      rwBit    <= 1'b0;
      ackDrive <= 1'b0;
      mAck     <= 1'b0;
      rdSel    <= 1'b0;
      wrIdx    <= 2'd0;
    end else if (startDet) begin
      state    <= ST_ADDR;
      bitCnt   <= '0;
      gotByte  <= 1'b0;
      ackDrive <= 1'b0;
    end else if (stopDet) begin
      state    <= ST_IDLE;
      ackDrive <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_WRB: begin
          if (sclRise) begin
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == LAST_BIT) gotByte <= 1'b1;
          end
          if (sclFall && gotByte) begin
            gotByte <= 1'b0;
            if (state == ST_WRB) begin
              ackDrive <= 1'b1;
              state    <= ST_WACK;
            end else if (rxByte[BYTE_W-1:1] == myAddr) begin
              ackDrive <= 1'b1;
              rwBit    <= rxByte[0];
              wrIdx    <= 2'd0;
              rdSel    <= 1'b0;
              state    <= ST_AACK;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_AACK: begin
          if (sclFall) begin
            ackDrive <= 1'b0;
            bitCnt   <= '0;
            state    <= rwBit ? ST_RDB : ST_WRB;
          end
        end
        ST_WACK: begin
          if (sclFall) begin
            ackDrive <= 1'b0;
            bitCnt   <= '0;
            state    <= ST_WRB;
            if (wrIdx != 2'd2) wrIdx <= wrIdx + 1'b1;
          end
        end
        ST_RDB: begin
          if (sclRise) begin
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == LAST_BIT) gotByte <= 1'b1;
          end
          if (sclFall && gotByte) begin
            gotByte <= 1'b0;
            state   <= ST_RACK;
          end
        end
        ST_RACK: begin
          if (sclRise) mAck <= ~sdaF;
          if (sclFall) begin
            if (mAck) begin
              bitCnt <= '0;
              rdSel  <= ~rdSel;
              state  <= ST_RDB;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sdaDriveLow = ackDrive | ((state == ST_RDB) & ~txMsb);
endmodule

// File: rtl/i2cRegDatapath.sv
`timescale 1ns/1ps
module i2cRegDatapath
  import i2cRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              powerGood,
  input  strobeT            strb,
  input  logic              sdaF,
  input  logic              thermalFault,
  input  logic              overload1,
  input  logic              overload2,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txMsb,
  output logic [CTRL_W-1:0] ctrlOut1,
  output logic [CTRL_W-1:0] ctrlOut2
);
  logic [BYTE_W-1:0] rxShreg, txShreg;
  logic [CTRL_W-1:0] reg1, reg2;

  always_ff @(posedge clk) begin
    if (!rstN || !powerGood) begin
      rxShreg <= '0;
      txShreg <= '1;
      reg1    <= '0;
      reg2    <= '0;
    end else begin
      if (strb.rxShift) rxShreg <= {rxShreg[BYTE_W-2:0], sdaF};
      if (strb.wrReg1)  reg1 <= rxShreg[CTRL_W-1:0];
      if (strb.wrReg2)  reg2 <= rxShreg[CTRL_W-1:0];
      if (strb.txLoad) begin
        txShreg <= strb.txSel ? {overload2, thermalFault, reg2}
                              : {overload1, thermalFault, reg1};
      end else if (strb.txShift) begin
        txShreg <= {txShreg[BYTE_W-2:0], 1'b1};
      end
    end
  end

  assign rxByte   = rxShreg;
  assign txMsb    = txShreg[BYTE_W-1];
  assign ctrlOut1 = reg1;
  assign ctrlOut2 = reg2;
endmodule

// File: rtl/pwrCtrlI2cSlave.sv
`timescale 1ns/1ps
module pwrCtrlI2cSlave
  import i2cRegPkg::*;
#(
  parameter logic [6:0] ADDR_BASE = 7'b0001000,
  parameter int         FILT_LEN  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              powerGood,
  input  logic              addrSel,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaDriveLow,
  input  logic              thermalFault,
  input  logic              overload1,
  input  logic              overload2,
  output logic [CTRL_W-1:0] ctrlOut1,
  output logic [CTRL_W-1:0] ctrlOut2
);
  strobeT            strb;
  logic              sdaF, sclRise, sclFall, startDet, stopDet, txMsb;
  logic [BYTE_W-1:0] rxByte;

  i2cLineFilter #(.FILT_LEN(FILT_LEN)) uFront (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sdaF(sdaF), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  i2cSlaveCtrl #(.ADDR_BASE(ADDR_BASE)) uCtrl (
    .clk(clk), .rstN(rstN), .powerGood(powerGood), .addrSel(addrSel),
    .sdaF(sdaF), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .txMsb(txMsb),
    .rxByte(rxByte), .strb(strb), .sdaDriveLow(sdaDriveLow)
  );

  i2cRegDatapath uData (
    .clk(clk), .rstN(rstN), .powerGood(powerGood), .strb(strb),
    .sdaF(sdaF), .thermalFault(thermalFault), .overload1(overload1),
    .overload2(overload2), .rxByte(rxByte), .txMsb(txMsb),
    .ctrlOut1(ctrlOut1), .ctrlOut2(ctrlOut2)
  );
endmodule

// File: rtl/i2cCtrlChecker.sv
`timescale 1ns/1ps
module i2cCtrlChecker
  import i2cRegPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              powerGood,
  input logic              sdaDriveLow,
  input logic [CTRL_W-1:0] ctrlOut1,
  input logic [CTRL_W-1:0] ctrlOut2,
  input logic              wr1,
  input logic              wr2
);
  AST_PG_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !powerGood |=> (ctrlOut1 == '0 && ctrlOut2 == '0)); // R8
  AST_PG_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    !powerGood |=> !sdaDriveLow); // R8
  AST_REG1_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlOut1 != $past(ctrlOut1)) |-> ($past(wr1) || !$past(powerGood))); // R2
  AST_REG2_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlOut2 != $past(ctrlOut2)) |-> ($past(wr2) || !$past(powerGood))); // R2
  AST_EN1_WITH_CFG: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlOut1[0]) |-> $past(wr1)); // R9
  AST_EN2_WITH_CFG: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlOut2[0]) |-> $past(wr2)); // R9
endmodule

bind pwrCtrlI2cSlave i2cCtrlChecker uChk (
  .clk(clk), .rstN(rstN), .powerGood(powerGood), .sdaDriveLow(sdaDriveLow),
  .ctrlOut1(ctrlOut1), .ctrlOut2(ctrlOut2),
  .wr1(strb.wrReg1), .wr2(strb.wrReg2)
);

// File: tb/tb_pwrCtrlI2cSlave.sv
`timescale 1ns/1ps
module tb_pwrCtrlI2cSlave;
  localparam int Q = 20;

  logic clk = 1'b0;
  logic rstN, powerGood, addrSel, sclM, sdaM;
  logic thermalFault, overload1, overload2;
  logic sdaDriveLow, sdaBus;
  logic [5:0] ctrlOut1, ctrlOut2;
  int nVec = 0, nBad = 0;
  logic [4:0] expCfg1, expCfg2;
  logic prevEn1 = 1'b0, prevEn2 = 1'b0;
  int enBad = 0;

  always #2.5 clk = ~clk;
  assign sdaBus = sdaM & ~sdaDriveLow;

  pwrCtrlI2cSlave dut (
    .clk(clk), .rstN(rstN), .powerGood(powerGood), .addrSel(addrSel),
    .sclIn(sclM), .sdaIn(sdaBus), .sdaDriveLow(sdaDriveLow),
    .thermalFault(thermalFault), .overload1(overload1), .overload2(overload2),
    .ctrlOut1(ctrlOut1), .ctrlOut2(ctrlOut2)
  );

  // R9 monitor: an enable must never rise while the configuration is stale
  always @(negedge clk) begin
    if (ctrlOut1[0] && !prevEn1 && ctrlOut1[5:1] != expCfg1) enBad++;
    if (ctrlOut2[0] && !prevEn2 && ctrlOut2[5:1] != expCfg2) enBad++;
    prevEn1 <= ctrlOut1[0];
    prevEn2 <= ctrlOut2[0];
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic startCond();
    sdaM = 1'b1; sclM = 1'b1; tick(Q);
    sdaM = 1'b0; tick(Q);
    sclM = 1'b0; tick(Q);
  endtask

  task automatic stopCond();
    sdaM = 1'b0; tick(Q);
    sclM = 1'b1; tick(Q);
    sdaM = 1'b1; tick(Q);
  endtask

  task automatic sendBit(input logic b, input bit glitch);
    sdaM = b;
    if (glitch) begin
      tick(Q/2); sclM = 1'b1; tick(2); sclM = 1'b0; tick(Q/2 - 2);
    end else begin
      tick(Q);
    end
    sclM = 1'b1; tick(2*Q);
    sclM = 1'b0; tick(Q);
  endtask

  task automatic recvBit(output logic b);
    sdaM = 1'b1; tick(Q);
    sclM = 1'b1; tick(Q);
    b = sdaBus;
    tick(Q);
    sclM = 1'b0; tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] v, input bit glitch, output logic nack);
    for (int k = 7; k >= 0; k--) sendBit(v[k], glitch);
    recvBit(nack);
  endtask

  task automatic readByte(output logic [7:0] v, input bit ack, input bit flipTherm);
    logic b;
    for (int k = 7; k >= 0; k--) begin
      recvBit(b);
      v[k] = b;
      if (flipTherm && k == 6) thermalFault = ~thermalFault;
    end
    sendBit(!ack, 1'b0);
  endtask

  task automatic writeRegs(input logic sel, input logic [7:0] d1, input logic [7:0] d2,
                           input bit extra, input bit glitch, input string tag);
    logic n;
    startCond();
    sendByte({7'b0001000 | {6'b0, sel}, 1'b0}, 1'b0, n);
    chk({tag, " addr ack"}, n, 0);
    sendByte(d1, glitch, n);
    chk({tag, " data1 ack"}, n, 0);
    sendByte(d2, 1'b0, n);
    chk({tag, " data2 ack"}, n, 0);
    if (extra) begin
      sendByte(8'hFF, 1'b0, n);
      chk("R3 extra byte ack", n, 0);
    end
    stopCond();
  endtask

  initial begin
    logic n;
    logic [7:0] b0, b1, b2;
    rstN = 1'b0; powerGood = 1'b0; addrSel = 1'b0; sclM = 1'b1; sdaM = 1'b1;
    thermalFault = 1'b0; overload1 = 1'b0; overload2 = 1'b0;
    expCfg1 = '0; expCfg2 = '0;
    tick(10);
    rstN = 1'b1;
    tick(5);
    chk("R8 reset ctrlOut1", ctrlOut1, 0);
    chk("R8 reset ctrlOut2", ctrlOut2, 0);
    chk("R8 reset sda released", sdaDriveLow, 0);

    // R8: no response while power is not good
    startCond();
    sendByte(8'h10, 1'b0, n);
    chk("R8 unpowered address nack", n, 1);
    sendByte(8'h3F, 1'b0, n);
    stopCond();
    chk("R8 unpowered ctrlOut1", ctrlOut1, 0);

    powerGood = 1'b1;
    tick(5);

    // R1: address sweep for both select levels
    for (int s = 0; s < 2; s++) begin
      addrSel = s[0];
      for (int a = 0; a < 18; a++) begin
        logic [6:0] ad;
        ad = (a < 16) ? 7'(a) : ((a == 16) ? 7'h48 : 7'h49);
        startCond();
        sendByte({ad, 1'b0}, 1'b0, n);
        stopCond();
        chk($sformatf("R1 addr %0h sel %0d ack", ad, s), n,
            (ad == (7'b0001000 | 7'(s))) ? 0 : 1);
      end
    end
    chk("R1 stray acks left regs", ctrlOut1, 0);

    // R2 R3 R4 R5 R7 R9: write/read sweep
    for (int i = 0; i < 16; i++) begin
      logic [7:0] v1, v2, e0, e1;
      v1 = 8'(i * 37 + 5);
      v2 = 8'(i * 91 + 200);
      addrSel = i[0];
      expCfg1 = v1[5:1];
      expCfg2 = v2[5:1];
      writeRegs(i[0], v1, v2, 1'b1, 1'b0, "R2");
      chk("R2 ctrlOut1 after write", ctrlOut1, {26'b0, v1[5:0]});
      chk("R3 ctrlOut2 kept after extra byte", ctrlOut2, {26'b0, v2[5:0]});
      overload1 = i[0]; overload2 = i[1]; thermalFault = i[2];
      e0 = {i[0], i[2], v1[5:0]};
      e1 = {i[1], i[2], v2[5:0]};
      startCond();
      sendByte({7'b0001000 | {6'b0, i[0]}, 1'b1}, 1'b0, n);
      chk("R4 read addr ack", n, 0);
      readByte(b0, 1'b1, 1'b0);
      readByte(b1, 1'b1, 1'b0);
      readByte(b2, 1'b0, 1'b0);
      chk("R5 read byte ch1", b0, e0);
      chk("R5 read byte ch2", b1, e1);
      chk("R4 third byte wraps to ch1", b2, e0);
      tick(Q);
      chk("R7 sda released after nack", sdaDriveLow, 0);
      begin
        logic bb;
        recvBit(bb);
        chk("R7 no further data after nack", bb, 1);
      end
      stopCond();
    end
    chk("R9 enable never ahead of config", enBad, 0);

    // R6: status captured at byte load
    addrSel = 1'b0; thermalFault = 1'b0; overload1 = 1'b0; overload2 = 1'b0;
    startCond();
    sendByte(8'h11, 1'b0, n);
    readByte(b0, 1'b1, 1'b1);
    readByte(b1, 1'b0, 1'b0);
    stopCond();
    chk("R6 flag frozen within byte", b0[6], 0);
    chk("R6 flag seen in next byte", b1[6], 1);

    // R10: short SCL glitches during first data byte
    thermalFault = 1'b0;
    expCfg1 = 5'(8'h2B >> 1); expCfg2 = 5'(8'h15 >> 1);
    writeRegs(1'b0, 8'h2B, 8'h15, 1'b0, 1'b1, "R10");
    chk("R10 glitched byte stored", ctrlOut1, 6'h2B);
    chk("R10 following byte stored", ctrlOut2, 6'h15);

    // R8: power loss clears, registers stay zero after return
    powerGood = 1'b0;
    tick(5);
    chk("R8 power drop ctrlOut1", ctrlOut1, 0);
    chk("R8 power drop ctrlOut2", ctrlOut2, 0);
    powerGood = 1'b1;
    tick(5);
    overload2 = 1'b1;
    startCond();
    sendByte(8'h11, 1'b0, n);
    readByte(b0, 1'b1, 1'b0);
    readByte(b1, 1'b0, 1'b0);
    stopCond();
    chk("R8 read after repower ch1", b0, 8'h00);
    chk("R8 read after repower ch2", b1, 8'h80);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule